// File: doc/BRIEF.md
# DRAM Cycle Type Classifier

This block watches the five active-low control strobes of an asynchronous DRAM interface (row strobe, low-byte column strobe, high-byte column strobe, write enable and output enable), samples them on a fast system clock and names every memory cycle it sees. It can sit beside a memory bus as a protocol checker, or act as the front end of a DRAM emulator, which then needs only the reported cycle kind and byte lanes to act.

Classification depends on the order in which strobe edges arrive, not on the strobe levels seen at one instant. A column strobe that is already active when the row strobe falls makes a refresh, not an access. Write enable falling before the first column strobe makes an early write, while falling later makes a late write or a read-modify-write. A column strobe held across a row strobe high pulse makes a hidden refresh. Electrical timing is not examined. Each report is a single-clock pulse that carries a 4-bit cycle code and a 2-bit byte-lane mask.

Top module: `dram_cycle_classifier`

## Requirements
- R1: During reset and in every clock where `cyc_valid` is low, `cyc_type` and `lane_mask` are both 0, which is the standby code.
- R2: Each strobe passes through a two-flop synchroniser. The report for a closing strobe change goes high right after the second rising edge that follows the first edge that sampled that change.
- R3: A row-strobe low period with neither column strobe active is reported when the row strobe rises, as code 5 (row-only refresh) with lane mask 0.
- R4: If a column strobe is active on the first sample with the row strobe low, the period is reported when the row strobe rises as code 6 (column-before-row refresh). The lane mask is the OR of the lanes active during that period.
- R5: Write enable low on or before the sample in which a column access starts gives code 2 (early write).
- R6: If write enable first goes low inside an access, the code is 4 (read-modify-write) when output enable was low on an earlier sample of that access, and 3 (late write) otherwise. An access with no write gives code 1 (read).
- R7: Lane mask bit 0 is set by the low-byte column strobe and bit 1 by the high-byte one, ORed over the access. Bit 0 alone means low byte, bit 1 alone means high byte, and both mean a word.
- R8: A column access ends when both column strobes are high or when the row strobe rises, and it is reported at that point. The second and later accesses in one row-strobe low period have bit 3 set (codes 9 to 12).
- R9: If an access ends because the row strobe rose while a column strobe stayed active, and the row strobe then falls again before both column strobes go high, that new period is reported at its row rise as code 7 (hidden refresh), with the OR of the lanes held.
- R10: `cyc_valid` is a single-clock pulse, and each cycle or access gives exactly one report.
- R11: Write enable, output enable and column strobe activity while the row strobe is high and no access is being held produce no report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| casl_n | input | 1 | Low-byte column strobe, active low |
| cash_n | input | 1 | High-byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| cyc_valid | output | 1 | One-clock report pulse |
| cyc_type | output | 4 | Cycle code (0 standby, 1 to 7 base kinds, bit 3 page flag) |
| lane_mask | output | 2 | Byte lanes involved in the reported cycle |

## Verification
The assertions assume that each strobe level holds for at least one sample, so the synchronised view keeps the real order of edges. They also assume that edges which land in the same sample are meant to be simultaneous. The stimulus changes the strobes only on the falling clock edge and holds every level for one or more whole periods. Simultaneous changes occur only where a scenario sets out to test them, and the reference model resolves them by the same row-first priority that the requirements state.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

  localparam int LANES = 2;

  // Cycle codes reported on cyc_type
  localparam logic [3:0] CT_STANDBY  = 4'h0;
  localparam logic [3:0] CT_READ     = 4'h1;
  localparam logic [3:0] CT_EARLY_WR = 4'h2;
  localparam logic [3:0] CT_LATE_WR  = 4'h3;
  localparam logic [3:0] CT_RMW      = 4'h4;
  localparam logic [3:0] CT_ROW_REF  = 4'h5;
  localparam logic [3:0] CT_CBR_REF  = 4'h6;
  localparam logic [3:0] CT_HID_REF  = 4'h7;
  localparam logic [3:0] CT_PAGE     = 4'h8;

  typedef enum logic [2:0] {
    ST_IDLE,  // row high, nothing held
    ST_ROW,   // row low, no column yet
    ST_COL,   // column access open
    ST_GAP,   // row low between page accesses
    ST_CBR,   // refresh: column before row
    ST_HOLD,  // row high, column held from previous period
    ST_HID    // row low again under a held column
  } dcc_state_e;

  typedef struct packed {
    logic ras_n;
    logic casl_n;
    logic cash_n;
    logic we_n;
    logic oe_n;
  } strobe_t;

endpackage

// File: rtl/dcc_sync.sv
module dcc_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/dcc_optrack.sv
module dcc_optrack
  import dcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,     // first sample of an access or refresh period
  input  logic             track,     // later samples of the same period
  input  logic [LANES-1:0] lanes,
  input  logic             we_n,
  input  logic             oe_n,
  output logic [LANES-1:0] lanes_acc,
  output logic [3:0]       op_code
);

  logic             early_q, early_d;
  logic             wrote_q, wrote_d;
  logic             rmw_q,   rmw_d;
  logic             rdoe_q,  rdoe_d;
  logic [LANES-1:0] acc_q,   acc_d;
  logic             en;

  assign en = start | track;

  always_comb begin
    early_d = early_q;
    wrote_d = wrote_q;
    rmw_d   = rmw_q;
    rdoe_d  = rdoe_q;
    acc_d   = acc_q;
    if (start) begin
      acc_d   = lanes;
      early_d = ~we_n;
      wrote_d = ~we_n;
      rmw_d   = 1'b0;
      rdoe_d  = we_n & ~oe_n;
    end else if (track) begin
      acc_d = acc_q | lanes;
      if (!wrote_q) begin
        if (!we_n) begin
          wrote_d = 1'b1;
          rmw_d   = rdoe_q;
        end else if (!oe_n) begin
          rdoe_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      early_q <= 1'b0;
      wrote_q <= 1'b0;
      rmw_q   <= 1'b0;
      rdoe_q  <= 1'b0;
      acc_q   <= '0;
    end else if (en) begin
      early_q <= early_d;
      wrote_q <= wrote_d;
      rmw_q   <= rmw_d;
      rdoe_q  <= rdoe_d;
      acc_q   <= acc_d;
    end
  end

  always_comb begin
    if (early_q)      op_code = CT_EARLY_WR;
    else if (wrote_q) op_code = rmw_q ? CT_RMW : CT_LATE_WR;
    else              op_code = CT_READ;
  end

  assign lanes_acc = acc_q;

  // R6: once a write is seen inside an access it stays seen until a new start
  a_r6_write_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wrote_q && !start) |=> wrote_q);

  // R5: an early write is always also a write
  a_r5_early_is_write: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !we_n) |=> (early_q && wrote_q));

endmodule

// File: rtl/dcc_fsm.sv
module dcc_fsm
  import dcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic [LANES-1:0] lanes,
  input  logic [LANES-1:0] lanes_acc,
  input  logic [3:0]       op_code,
  output logic             start,
  output logic             track,
  output logic             rep_valid,
  output logic [3:0]       rep_type,
  output logic [LANES-1:0] rep_mask
);

  dcc_state_e       state_q, state_d;
  logic             page_q,  page_d;
  logic             v_q, v_d;
  logic [3:0]       t_q, t_d;
  logic [LANES-1:0] m_q, m_d;
  logic             cas_act;
  logic             ras_hi;

  assign cas_act = |lanes;
  assign ras_hi  = ras_n;

  always_comb begin
    state_d = state_q;
    page_d  = page_q;
    start   = 1'b0;
    track   = 1'b0;
    v_d     = 1'b0;
    t_d     = CT_STANDBY;
    m_d     = '0;
    case (state_q)
      ST_IDLE: begin
        if (!ras_hi) begin
          if (cas_act) begin
            state_d = ST_CBR;
            start   = 1'b1;
          end else begin
            state_d = ST_ROW;
            page_d  = 1'b0;
          end
        end
      end
      ST_ROW: begin
        if (ras_hi) begin
          v_d     = 1'b1;
          t_d     = CT_ROW_REF;
          state_d = ST_IDLE;
        end else if (cas_act) begin
          state_d = ST_COL;
          start   = 1'b1;
        end
      end
      ST_COL: begin
        if (ras_hi || !cas_act) begin
          v_d    = 1'b1;
          t_d    = op_code | (page_q ? CT_PAGE : CT_STANDBY);
          m_d    = lanes_acc;
          page_d = 1'b1;
          if (!ras_hi)      state_d = ST_GAP;
          else if (cas_act) state_d = ST_HOLD;
          else              state_d = ST_IDLE;
        end else begin
          track = 1'b1;
        end
      end
      ST_GAP: begin
        if (ras_hi) begin
          state_d = ST_IDLE;
        end else if (cas_act) begin
          state_d = ST_COL;
          start   = 1'b1;
        end
      end
      ST_CBR: begin
        if (ras_hi) begin
          v_d     = 1'b1;
          t_d     = CT_CBR_REF;
          m_d     = lanes_acc;
          state_d = cas_act ? ST_HOLD : ST_IDLE;
        end else begin
          track = 1'b1;
        end
      end
      ST_HOLD: begin
        if (!cas_act) begin
          state_d = ras_hi ? ST_IDLE : ST_ROW;
          page_d  = 1'b0;
        end else if (!ras_hi) begin
          state_d = ST_HID;
          start   = 1'b1;
        end
      end
      ST_HID: begin
        if (ras_hi) begin
          v_d     = 1'b1;
          t_d     = CT_HID_REF;
          m_d     = lanes_acc;
          state_d = cas_act ? ST_HOLD : ST_IDLE;
        end else begin
          track = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      page_q  <= 1'b0;
      v_q     <= 1'b0;
      t_q     <= CT_STANDBY;
      m_q     <= '0;
    end else begin
      state_q <= state_d;
      page_q  <= page_d;
      v_q     <= v_d;
      t_q     <= t_d;
      m_q     <= m_d;
    end
  end

  assign rep_valid = v_q;
  assign rep_type  = t_q;
  assign rep_mask  = m_q;

  // R10: a report never lasts two clocks
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    v_q |=> !v_q);

  // R1: quiet outputs outside a report
  a_r1_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !v_q |-> (t_q == CT_STANDBY && m_q == '0));

  // R3: row-only refresh carries no lanes
  a_r3_row_ref_no_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && t_q == CT_ROW_REF) |-> (m_q == '0));

  // R4 / R9: refresh reports driven by a column strobe name at least one lane
  a_r4_refresh_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && (t_q == CT_CBR_REF || t_q == CT_HID_REF)) |-> (m_q != '0));

  // R8: the page flag only decorates access codes
  a_r8_page_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && t_q[3]) |-> (t_q[2:0] >= 3'd1 && t_q[2:0] <= 3'd4 && m_q != '0));

  // R9: a hidden period is only entered from a held column
  a_r9_hidden_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_HID) |-> ($past(state_q) == ST_HOLD));

endmodule

// File: rtl/dram_cycle_classifier.sv
module dram_cycle_classifier
  import dcc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ras_n,
  input  logic       casl_n,
  input  logic       cash_n,
  input  logic       we_n,
  input  logic       oe_n,
  output logic       cyc_valid,
  output logic [3:0] cyc_type,
  output logic [1:0] lane_mask
);

  localparam int SW = $bits(strobe_t);

  logic             rst_core_n;
  strobe_t          raw;
  strobe_t          syn;
  logic [LANES-1:0] lanes;
  logic [LANES-1:0] lanes_acc;
  logic [3:0]       op_code;
  logic             start;
  logic             track;

  // reset: asserted at once, released through the same synchroniser
  dcc_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_core_n)
  );

  assign raw = {ras_n, casl_n, cash_n, we_n, oe_n};

  dcc_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL({SW{1'b1}})) u_strobe_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     (raw),
    .q     (syn)
  );

  assign lanes = {~syn.cash_n, ~syn.casl_n};

  dcc_optrack u_optrack (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .start     (start),
    .track     (track),
    .lanes     (lanes),
    .we_n      (syn.we_n),
    .oe_n      (syn.oe_n),
    .lanes_acc (lanes_acc),
    .op_code   (op_code)
  );

  dcc_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .ras_n     (syn.ras_n),
    .lanes     (lanes),
    .lanes_acc (lanes_acc),
    .op_code   (op_code),
    .start     (start),
    .track     (track),
    .rep_valid (cyc_valid),
    .rep_type  (cyc_type),
    .rep_mask  (lane_mask)
  );

endmodule

// File: tb/dram_cycle_classifier_bench.sv
module dram_cycle_classifier_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst_n;
  logic ras_n, casl_n, cash_n, we_n, oe_n;
  logic       cyc_valid;
  logic [3:0] cyc_type;
  logic [1:0] lane_mask;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_cycle_classifier u_dram_cycle_classifier (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .casl_n(casl_n), .cash_n(cash_n),
    .we_n(we_n), .oe_n(oe_n), .cyc_valid(cyc_valid), .cyc_type(cyc_type),
    .lane_mask(lane_mask)
  );

  // ---------------- behavioural reference model ----------------
  int       ph;          // 0 idle 1 row 2 col 3 gap 4 cbr 5 hold 6 hid
  bit       pg, e_early, e_wrote, e_rmw, e_rdoe;
  int       acc;
  logic [6:0] mq[$];     // {valid, type, mask} per sampled edge

  function automatic int kind_of();
    if (e_early) return 2;
    if (e_wrote) return e_rmw ? 4 : 3;
    return 1;
  endfunction

  function automatic logic [6:0] model_step(logic r, logic l, logic h, logic w, logic o);
    int  ln;
    bit  act;
    logic [6:0] res;
    ln  = (h ? 0 : 2) + (l ? 0 : 1);
    act = (ln != 0);
    res = '0;
    if (ph == 2 || ph == 4 || ph == 6) begin
      if ((ph == 2 && (r || !act)) || (ph != 2 && r)) begin
        if (ph == 2) begin
          res = {1'b1, 4'(kind_of() + (pg ? 8 : 0)), 2'(acc)};
          pg = 1;
          ph = !r ? 3 : (act ? 5 : 0);
        end else begin
          res = {1'b1, (ph == 4 ? 4'd6 : 4'd7), 2'(acc)};
          ph = act ? 5 : 0;
        end
      end else begin
        acc = acc | ln;
        if (ph == 2 && !e_wrote) begin
          if (!w) begin e_wrote = 1; e_rmw = e_rdoe; end
          else if (!o) e_rdoe = 1;
        end
      end
    end else if (ph == 0) begin
      if (!r) begin
        if (act) begin ph = 4; acc = ln; end
        else begin ph = 1; pg = 0; end
      end
    end else if (ph == 1 || ph == 3) begin
      if (r) begin
        if (ph == 1) res = {1'b1, 4'd5, 2'd0};
        ph = 0;
      end else if (act) begin
        ph = 2; acc = ln; e_early = !w; e_wrote = !w; e_rmw = 0; e_rdoe = w && !o;
      end
    end else begin // hold
      if (!act) begin ph = r ? 0 : 1; pg = 0; end
      else if (!r) begin ph = 6; acc = ln; end
    end
    return res;
  endfunction

  always @(posedge clk) begin : model_proc
    logic [6:0] r;
    if (!rst_n) begin
      ph = 0; pg = 0; acc = 0; e_early = 0; e_wrote = 0; e_rmw = 0; e_rdoe = 0;
      mq.delete();
    end else begin
      r = model_step(ras_n, casl_n, cash_n, we_n, oe_n);
      mq.push_back(r);
    end
  end

  function automatic string tag_of(logic [6:0] e, logic [6:0] a);
    if (e[6] != a[6]) return "R2";
    if (e[5:2] == a[5:2] && e[1:0] != a[1:0]) return "R7";
    case (e[5:2])
      4'd0: return "R1";
      4'd5: return "R3";
      4'd6: return "R4";
      4'd2: return "R5";
      4'd7: return "R9";
      default: return (e[5] ? "R8" : "R6");
    endcase
  endfunction

  // per-clock comparison (R2 timing and all codes)
  always @(negedge clk) begin : cmp_proc
    logic [6:0] e;
    logic [6:0] a;
    if (rst_n && mq.size() == 3) begin
      e = mq.pop_front();
      a = {cyc_valid, cyc_type, lane_mask};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s per-clock model mismatch: actual=%h expected=%h", tag_of(e, a), a, e);
      end
    end
  end

  // capture of reports for directed checks
  logic [5:0] rq[$];
  always @(negedge clk) if (rst_n && cyc_valid === 1'b1) rq.push_back({cyc_type, lane_mask});

  // ---------------- helpers ----------------
  task automatic drv(input logic r, input logic l, input logic h, input logic w,
                     input logic o, input int n);
    ras_n = r; casl_n = l; cash_n = h; we_n = w; oe_n = o;
    repeat (n) @(negedge clk);
  endtask

  task automatic idle(input int n);
    drv(1, 1, 1, 1, 1, n);
  endtask

  task automatic exp_rep(input string req, input logic [3:0] t, input logic [1:0] m);
    logic [5:0] got;
    checks++;
    if (rq.size() == 0) begin
      errors++;
      $display("FAIL %s missing report: actual=none expected=%h/%h", req, t, m);
    end else begin
      got = rq.pop_front();
      if (got !== {t, m}) begin
        errors++;
        $display("FAIL %s report: actual=%h/%h expected=%h/%h", req, got[5:2], got[1:0], t, m);
      end
    end
  endtask

  task automatic exp_none(input string req);
    checks++;
    if (rq.size() != 0) begin
      errors++;
      $display("FAIL %s unexpected report count: actual=%0d expected=0", req, rq.size());
      rq.delete();
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int lat;
    rst_n = 0;
    ras_n = 1; casl_n = 1; cash_n = 1; we_n = 1; oe_n = 1;
    repeat (4) @(negedge clk);
    // R1: reset state
    checks++;
    if (cyc_valid !== 1'b0 || cyc_type !== 4'd0 || lane_mask !== 2'd0) begin
      errors++;
      $display("FAIL R1 reset outputs: actual=%b/%h/%h expected=0/0/0", cyc_valid, cyc_type, lane_mask);
    end
    rst_n = 1;
    idle(8);

    // R3 + R2: row-only refresh and its latency
    drv(0, 1, 1, 1, 1, 4);
    ras_n = 1;
    lat = 0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (cyc_valid === 1'b1 && lat == 0) lat = i;
    end
    checks++;
    if (lat != 3) begin
      errors++;
      $display("FAIL R2 report latency: actual=%0d expected=3", lat);
    end
    exp_rep("R3", 4'd5, 2'b00);
    exp_none("R10");

    // R6 / R7: word read, low-byte read, high-byte read
    drv(0, 1, 1, 1, 1, 2); drv(0, 0, 0, 1, 0, 3); drv(0, 1, 1, 1, 1, 2); idle(6);
    exp_rep("R6", 4'd1, 2'b11);
    drv(0, 1, 1, 1, 1, 2); drv(0, 0, 1, 1, 0, 3); drv(0, 1, 1, 1, 1, 2); idle(6);
    exp_rep("R7", 4'd1, 2'b01);
    drv(0, 1, 1, 1, 1, 2); drv(0, 1, 0, 1, 0, 3); drv(0, 1, 1, 1, 1, 2); idle(6);
    exp_rep("R7", 4'd1, 2'b10);
    // R7: lanes ORed when the second strobe joins late
    drv(0, 1, 1, 1, 1, 2); drv(0, 0, 1, 1, 0, 2); drv(0, 0, 0, 1, 0, 2); drv(0, 1, 1, 1, 1, 2); idle(6);
    exp_rep("R7", 4'd1, 2'b11);

    // R5: early write
    drv(1, 1, 1, 0, 1, 2); drv(0, 1, 1, 0, 1, 2); drv(0, 0, 0, 0, 1, 3); drv(0, 1, 1, 1, 1, 2); idle(6);
    exp_rep("R5", 4'd2, 2'b11);

    // R6: late write (OE high throughout)
    drv(0, 1, 1, 1, 1, 2); drv(0, 0, 0, 1, 1, 3); drv(0, 0, 0, 0, 1, 3); drv(0, 1, 1, 1, 1, 2); idle(6);
    exp_rep("R6", 4'd3, 2'b11);

    // R6: read-modify-write (OE low first, then WE)
    drv(0, 1, 1, 1, 1, 2); drv(0, 0, 0, 1, 0, 3); drv(0, 0, 0, 1, 1, 1); drv(0, 0, 0, 0, 1, 3);
    drv(0, 1, 1, 1, 1, 2); idle(6);
    exp_rep("R6", 4'd4, 2'b11);

    // R8: page mode: read, low-byte read, high-byte early write
    drv(0, 1, 1, 1, 1, 2); drv(0, 0, 0, 1, 0, 3); drv(0, 1, 1, 1, 1, 2);
    drv(0, 0, 1, 1, 0, 3); drv(0, 1, 1, 0, 1, 2); drv(0, 1, 0, 0, 1, 3);
    drv(0, 1, 1, 1, 1, 2); idle(6);
    exp_rep("R8", 4'd1, 2'b11);
    exp_rep("R8", 4'd9, 2'b01);
    exp_rep("R8", 4'hA, 2'b10);
    exp_none("R10");

    // R4: column-before-row refresh with one lane
    drv(1, 0, 1, 1, 1, 3); drv(0, 0, 1, 1, 1, 4); drv(1, 0, 1, 1, 1, 3); idle(6);
    exp_rep("R4", 4'd6, 2'b01);
    exp_none("R4");

    // R9: read, then hidden refresh under a held column
    drv(0, 1, 1, 1, 1, 3); drv(0, 0, 0, 1, 0, 3); drv(1, 0, 0, 1, 0, 3);
    drv(0, 0, 0, 1, 0, 3); drv(1, 0, 0, 1, 0, 3); idle(6);
    exp_rep("R8", 4'd1, 2'b11);
    exp_rep("R9", 4'd7, 2'b11);
    exp_none("R9");

    // R8: access ended by the row strobe, column released with no hidden period
    drv(0, 1, 1, 1, 1, 2); drv(0, 1, 0, 1, 0, 3); drv(1, 1, 0, 1, 0, 3); idle(6);
    exp_rep("R8", 4'd1, 2'b10);
    exp_none("R8");

    // R11: activity while the row strobe is high is ignored
    drv(1, 1, 1, 0, 1, 2); drv(1, 1, 1, 1, 0, 2); drv(1, 0, 1, 0, 0, 2);
    drv(1, 1, 0, 1, 1, 2); idle(8);
    exp_none("R11");

    idle(4);
    done = 1;
    finish_run();
  end

endmodule